// File: doc/BRIEF.md
# Processor Power-State Controller

This block follows the power state of a processor core through five states: Normal Execution (`ST_NORMAL`), Halt (`ST_HALT`), Stop Grant (`ST_STPGNT`), Stop Grant Inquire (`ST_INQ`) and Stop Clock (`ST_STPCLK`). Four of them are low-power states. The block takes the following inputs:

- a one-cycle halt strobe from the core;
- five wake events: reset, init, system-management interrupt, non-maskable interrupt and maskable interrupt;
- a stop-clock request;
- a snoop inquire request;
- an indication that the input clock is present.

It drives a one-hot state vector, a core clock enable and a one-cycle stop-grant acknowledge. It also drives a code that tells which wake event caused the last exit.

The named transitions are listed below. Where more than one could apply in the same cycle, the one listed first wins, and *reset-event* wins in every state.

- *reset-event*: any state goes to `ST_NORMAL`.
- *stop-from-normal*: `ST_NORMAL` goes to `ST_STPGNT`.
- *halt-entry*: `ST_NORMAL` goes to `ST_HALT`.
- *stop-from-halt*: `ST_HALT` goes to `ST_STPGNT`.
- *wake*: `ST_HALT` goes to `ST_NORMAL`.
- *stop-release*: `ST_STPGNT` goes back to the state recorded when Stop Grant was entered.
- *inquire-start*: `ST_STPGNT` goes to `ST_INQ`.
- *clock-loss*: `ST_STPGNT` goes to `ST_STPCLK`.
- *inquire-end*: `ST_INQ` goes to `ST_STPGNT`.
- *clock-return*: `ST_STPCLK` goes to `ST_STPGNT`.

Stop Grant records whether it was entered from Halt or from Normal Execution. Outside power-management logic may stop the input clock once the stop has been granted. All state changes are registered and take effect on the clock edge that samples the inputs.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_ni` is low the block is in `ST_NORMAL`, `wake_cause_o` is 0 and `stpgnt_ack_o` is 0. After `rst_ni` is released the first clock edge also leaves it in `ST_NORMAL`, provided no request is active.
- R2: `state_oh_o` is one-hot. Bit 0 is `ST_NORMAL`, bit 1 `ST_HALT`, bit 2 `ST_STPGNT`, bit 3 `ST_INQ` and bit 4 `ST_STPCLK`.
- R3: In `ST_NORMAL`, a high `halt_i` with `stpclk_req_i` low moves to `ST_HALT` on the next edge (*halt-entry*).
- R4: In `ST_HALT`, with `stpclk_req_i` low, a high init, system-management, non-maskable or maskable wake input moves to `ST_NORMAL` on the next edge (*wake*). That edge also loads the wake cause.
- R5: A high `stpclk_req_i` moves to `ST_STPGNT` from `ST_NORMAL` (*stop-from-normal*) or from `ST_HALT` (*stop-from-halt*). It has priority over `halt_i` and over every wake input except reset.
- R6: `stpgnt_ack_o` is high for exactly the first cycle of `ST_STPGNT` after an entry from `ST_NORMAL` or `ST_HALT`. It is not raised on a return from `ST_INQ` or `ST_STPCLK`.
- R7: In `ST_STPGNT`, a low `stpclk_req_i` returns to the recorded origin state (*stop-release*). The origin is `ST_HALT` or `ST_NORMAL`.
- R8: In `ST_STPGNT` with `stpclk_req_i` high, a high `inq_req_i` moves to `ST_INQ` (*inquire-start*). This has priority over clock loss. `ST_INQ` returns to `ST_STPGNT` on the edge that samples `inq_req_i` low (*inquire-end*).
- R9: In `ST_STPGNT`, with `stpclk_req_i` high and `inq_req_i` low, a low `clk_present_i` moves to `ST_STPCLK` (*clock-loss*). `ST_STPCLK` returns to `ST_STPGNT` on the edge that samples `clk_present_i` high (*clock-return*).
- R10: A high `wake_rst_i` moves every state to `ST_NORMAL` on the next edge. That edge sets the wake cause to 1 and clears the recorded origin to `ST_NORMAL`.
- R11: The wake cause codes, from highest priority to lowest, are: reset 1, init 2, system-management 3, non-maskable 4, maskable 5. The highest-priority event present is reported, and the code holds until the next *wake* or *reset-event*.
- R12: `core_clk_en_o` is high in `ST_NORMAL`. In `ST_INQ` it is high only while `inq_req_i` is high. In `ST_HALT`, `ST_STPGNT` and `ST_STPCLK` it is low.
- R13: Non-reset wake inputs have no effect in `ST_NORMAL`, `ST_STPGNT`, `ST_INQ` or `ST_STPCLK`. Both the state and `wake_cause_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller |
| halt_i | input | 1 | Halt strobe from the core |
| wake_rst_i | input | 1 | Reset wake event |
| wake_init_i | input | 1 | Init wake event |
| wake_smi_i | input | 1 | System-management interrupt wake event |
| wake_nmi_i | input | 1 | Non-maskable interrupt wake event |
| wake_intr_i | input | 1 | Maskable interrupt wake event |
| stpclk_req_i | input | 1 | Stop-clock request, level |
| inq_req_i | input | 1 | Snoop inquire request, level |
| clk_present_i | input | 1 | High while the input clock is running |
| state_oh_o | output | 5 | One-hot power state |
| core_clk_en_o | output | 1 | Core clock enable |
| stpgnt_ack_o | output | 1 | One-cycle stop-grant acknowledge |
| wake_cause_o | output | 3 | Code of the last wake cause, 0 after reset |

## Verification
Directed sequences cover the following cases:

- a halt followed by each wake input, which tells the priority codes apart;
- several wake inputs at once, which checks the priority order;
- a stop request taken from Halt and one taken from Normal Execution, which tells the two recorded origins apart;
- an inquire request and a clock loss inside Stop Grant, including both at once to show that the inquire wins;
- a reset event raised from deep low-power states.

Wake inputs are also raised during Stop Grant, Inquire and Stop Clock to show that they change neither the state nor the cause. A long seeded random run with sticky, slowly changing request levels then checks the state, the acknowledge, the cause and the clock enable every cycle against a bench model.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
    localparam int NUM_STATES = 5;
    localparam int NUM_WAKE   = 5;
    localparam int CAUSE_W    = $clog2(NUM_WAKE + 1);

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_HALT   = 3'd1,
        ST_STPGNT = 3'd2,
        ST_INQ    = 3'd3,
        ST_STPCLK = 3'd4
    } pwr_state_t;

    // wake event vector bit positions, also the priority order (0 highest)
    localparam int WK_RST  = 0;
    localparam int WK_INIT = 1;
    localparam int WK_SMI  = 2;
    localparam int WK_NMI  = 3;
    localparam int WK_INTR = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = '0;
    localparam logic [CAUSE_W-1:0] CAUSE_RESET = CAUSE_W'(1);
endpackage

// File: rtl/pwr_wake_enc.sv
module pwr_wake_enc
    import pwr_state_pkg::*;
#(
    parameter int N_EVT = NUM_WAKE,
    localparam int CW   = $clog2(N_EVT + 1)
) (
    input  logic [N_EVT-1:0] evt_i,
    output logic             any_o,
    output logic [CW-1:0]    code_o
);
    // code is bit index + 1 of the lowest-numbered (highest priority) event
    always_comb begin
        code_o = '0;
        for (int i = N_EVT - 1; i >= 0; i--) begin
            if (evt_i[i]) code_o = CW'(i + 1);
        end
    end

    assign any_o = |evt_i;

    always_comb begin
        if (any_o) assert (code_o != '0);
    end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_state_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  halt_i,
    input  logic                  rst_evt_i,
    input  logic                  soft_wake_i,
    input  logic [CAUSE_W-1:0]    soft_code_i,
    input  logic                  stpclk_req_i,
    input  logic                  inq_req_i,
    input  logic                  clk_present_i,
    output logic [NUM_STATES-1:0] state_oh_o,
    output logic                  core_clk_en_o,
    output logic                  stpgnt_ack_o,
    output logic [CAUSE_W-1:0]    wake_cause_o
);
    pwr_state_t       state_q, state_d;
    pwr_state_t       origin_q, origin_d;
    logic [CAUSE_W-1:0] cause_q, cause_d;
    logic             ack_q, ack_d;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        origin_d = origin_q;
        cause_d  = cause_q;
        ack_d    = 1'b0;
        if (rst_evt_i) begin
            state_d  = ST_NORMAL;
            origin_d = ST_NORMAL;
            cause_d  = CAUSE_RESET;
        end else begin
            unique case (state_q)
                ST_NORMAL: begin
                    if (stpclk_req_i) begin
                        state_d  = ST_STPGNT;
                        origin_d = ST_NORMAL;
                        ack_d    = 1'b1;
                    end else if (halt_i) begin
                        state_d = ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (stpclk_req_i) begin
                        state_d  = ST_STPGNT;
                        origin_d = ST_HALT;
                        ack_d    = 1'b1;
                    end else if (soft_wake_i) begin
                        state_d = ST_NORMAL;
                        cause_d = soft_code_i;
                    end
                end
                ST_STPGNT: begin
                    if (!stpclk_req_i)      state_d = origin_q;
                    else if (inq_req_i)     state_d = ST_INQ;
                    else if (!clk_present_i) state_d = ST_STPCLK;
                end
                ST_INQ: begin
                    if (!inq_req_i) state_d = ST_STPGNT;
                end
                ST_STPCLK: begin
                    if (clk_present_i) state_d = ST_STPGNT;
                end
                default: state_d = ST_NORMAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_NORMAL;
            origin_q <= ST_NORMAL;
            cause_q  <= CAUSE_NONE;
            ack_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            origin_q <= origin_d;
            cause_q  <= cause_d;
            ack_q    <= ack_d;
        end
    end

    // outputs
    always_comb begin
        state_oh_o    = '0;
        core_clk_en_o = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin state_oh_o[0] = 1'b1; core_clk_en_o = 1'b1;      end
            ST_HALT:   begin state_oh_o[1] = 1'b1;                            end
            ST_STPGNT: begin state_oh_o[2] = 1'b1;                            end
            ST_INQ:    begin state_oh_o[3] = 1'b1; core_clk_en_o = inq_req_i; end
            ST_STPCLK: begin state_oh_o[4] = 1'b1;                            end
            default:   begin state_oh_o    = '0;                              end
        endcase
        stpgnt_ack_o = ack_q;
        wake_cause_o = cause_q;
    end

    // R2
    a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(state_oh_o) == 1);
    // R3
    a_r3_halt_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_NORMAL && halt_i && !stpclk_req_i && !rst_evt_i) |=> state_q == ST_HALT);
    // R5
    a_r5_stop_in_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT && stpclk_req_i && !rst_evt_i) |=> (state_q == ST_STPGNT && stpgnt_ack_o));
    // R6
    a_r6_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stpgnt_ack_o |=> !stpgnt_ack_o);
    // R10
    a_r10_reset_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_evt_i |=> (state_q == ST_NORMAL && wake_cause_o == CAUSE_RESET));
    // R13
    a_r13_cause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_HALT && !rst_evt_i) |=> $stable(wake_cause_o));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  halt_i,
    input  logic                  wake_rst_i,
    input  logic                  wake_init_i,
    input  logic                  wake_smi_i,
    input  logic                  wake_nmi_i,
    input  logic                  wake_intr_i,
    input  logic                  stpclk_req_i,
    input  logic                  inq_req_i,
    input  logic                  clk_present_i,
    output logic [NUM_STATES-1:0] state_oh_o,
    output logic                  core_clk_en_o,
    output logic                  stpgnt_ack_o,
    output logic [CAUSE_W-1:0]    wake_cause_o
);
    logic [NUM_WAKE-1:0] evt;
    logic                any_evt;
    logic [CAUSE_W-1:0]  evt_code;

    always_comb begin
        evt          = '0;
        evt[WK_RST]  = wake_rst_i;
        evt[WK_INIT] = wake_init_i;
        evt[WK_SMI]  = wake_smi_i;
        evt[WK_NMI]  = wake_nmi_i;
        evt[WK_INTR] = wake_intr_i;
    end

    pwr_wake_enc #(.N_EVT(NUM_WAKE)) u_enc (
        .evt_i  (evt),
        .any_o  (any_evt),
        .code_o (evt_code)
    );

    pwr_fsm u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .halt_i        (halt_i),
        .rst_evt_i     (wake_rst_i),
        .soft_wake_i   (any_evt),
        .soft_code_i   (evt_code),
        .stpclk_req_i  (stpclk_req_i),
        .inq_req_i     (inq_req_i),
        .clk_present_i (clk_present_i),
        .state_oh_o    (state_oh_o),
        .core_clk_en_o (core_clk_en_o),
        .stpgnt_ack_o  (stpgnt_ack_o),
        .wake_cause_o  (wake_cause_o)
    );

    // R12
    a_r12_clk_off_low_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_oh_o[1] || state_oh_o[2] || state_oh_o[4]) |-> !core_clk_en_o);
endmodule

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 0, w_rst = 0, w_init = 0, w_smi = 0, w_nmi = 0, w_intr = 0;
    logic stp = 0, inq = 0, cp = 1;
    logic [4:0] st_oh;
    logic       clk_en, ack;
    logic [2:0] cause;

    int checks = 0;
    int errors = 0;

    // model state: 0 normal, 1 halt, 2 stop grant, 3 inquire, 4 stop clock
    int m_st = 0, m_ret = 0, m_cause = 0;
    bit m_ack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .halt_i(halt),
        .wake_rst_i(w_rst), .wake_init_i(w_init), .wake_smi_i(w_smi),
        .wake_nmi_i(w_nmi), .wake_intr_i(w_intr),
        .stpclk_req_i(stp), .inq_req_i(inq), .clk_present_i(cp),
        .state_oh_o(st_oh), .core_clk_en_o(clk_en),
        .stpgnt_ack_o(ack), .wake_cause_o(cause)
    );

    function automatic int prio_code(bit i, bit s, bit n, bit t);
        if (i) return 2;
        if (s) return 3;
        if (n) return 4;
        if (t) return 5;
        return 0;
    endfunction

    function automatic bit exp_clk_en(int st, bit q);
        return (st == 0) || (st == 3 && q);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int ns = m_st, nr = m_ret, nc = m_cause;
        bit na = 0;
        if (w_rst) begin
            ns = 0; nr = 0; nc = 1;
        end else begin
            case (m_st)
                0: if (stp) begin ns = 2; nr = 0; na = 1; end
                   else if (halt) ns = 1;
                1: if (stp) begin ns = 2; nr = 1; na = 1; end
                   else if (w_init || w_smi || w_nmi || w_intr) begin
                       ns = 0; nc = prio_code(w_init, w_smi, w_nmi, w_intr);
                   end
                2: if (!stp) ns = m_ret;
                   else if (inq) ns = 3;
                   else if (!cp) ns = 4;
                3: if (!inq) ns = 2;
                4: if (cp) ns = 2;
                default: ns = 0;
            endcase
        end
        m_st = ns; m_ret = nr; m_cause = nc; m_ack = na;
    endtask

    // inputs already set; one clock with full checks
    task automatic cyc(string rq_st, string rq_ack, string rq_cause, string rq_en);
        #1;
        chk(rq_en, int'(clk_en), int'(exp_clk_en(m_st, inq)));
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(rq_st, int'(st_oh), 1 << m_st);
        chk(rq_ack, int'(ack), int'(m_ack));
        chk(rq_cause, int'(cause), m_cause);
    endtask

    task automatic clear_pulses();
        halt = 0; w_rst = 0; w_init = 0; w_smi = 0; w_nmi = 0; w_intr = 0;
    endtask

    task automatic go(string rq);
        cyc(rq, rq, rq, rq);
        clear_pulses();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        #(CLK_PERIOD * 2 + 2);
        chk("R1 state in reset", int'(st_oh), 1);
        chk("R1 cause in reset", int'(cause), 0);
        chk("R1 ack in reset", int'(ack), 0);
        chk("R12 clk_en in reset", int'(clk_en), 1);
        @(negedge clk);
        rst_n = 1;
        go("R1");

        // R3 halt entry, R4/R11 wake by maskable interrupt
        halt = 1; go("R3");
        chk("R3 halt state", int'(st_oh), 5'b00010);
        chk("R12 clk_en in halt", int'(clk_en), 0);
        go("R3");
        w_intr = 1; go("R4");
        chk("R11 intr code", int'(cause), 5);
        // R11 init+nmi together
        halt = 1; go("R3");
        w_nmi = 1; w_init = 1; go("R11");
        chk("R11 init beats nmi", int'(cause), 2);
        halt = 1; go("R3");
        w_smi = 1; w_intr = 1; w_nmi = 1; go("R11");
        chk("R11 smi code", int'(cause), 3);

        // R13 wakes in normal ignored
        w_nmi = 1; go("R13");
        chk("R13 cause kept in normal", int'(cause), 3);

        // R5 stop from halt, R6 ack, R7 return to halt
        halt = 1; go("R3");
        stp = 1; w_intr = 1; go("R5");
        chk("R5 stop grant from halt", int'(st_oh), 5'b00100);
        chk("R6 ack on entry", int'(ack), 1);
        go("R6");
        chk("R6 ack one cycle", int'(ack), 0);
        // R13 wakes ignored in stop grant
        w_init = 1; w_intr = 1; go("R13");
        chk("R13 stays stop grant", int'(st_oh), 5'b00100);
        chk("R13 cause kept", int'(cause), 3);
        // R8 inquire with clock loss: inquire wins
        inq = 1; cp = 0; go("R8");
        chk("R8 inquire state", int'(st_oh), 5'b01000);
        #1 chk("R12 clk_en during inquire", int'(clk_en), 1);
        inq = 0; #1 chk("R12 clk_en inquire dropped", int'(clk_en), 0);
        go("R8");
        chk("R8 back to stop grant", int'(st_oh), 5'b00100);
        chk("R6 no ack on inquire return", int'(ack), 0);
        // R9 clock loss
        go("R9");
        chk("R9 stop clock", int'(st_oh), 5'b10000);
        w_smi = 1; go("R13");
        chk("R13 stays stop clock", int'(st_oh), 5'b10000);
        cp = 1; go("R9");
        chk("R9 clock return", int'(st_oh), 5'b00100);
        chk("R6 no ack on clock return", int'(ack), 0);
        stp = 0; go("R7");
        chk("R7 return to halt", int'(st_oh), 5'b00010);

        // R5 stop from normal beats halt, R7 return to normal
        w_intr = 1; go("R4");
        stp = 1; halt = 1; go("R5");
        chk("R5 stop beats halt", int'(st_oh), 5'b00100);
        chk("R6 ack from normal", int'(ack), 1);
        stp = 0; go("R7");
        chk("R7 return to normal", int'(st_oh), 5'b00001);

        // R10 reset event from stop clock clears origin
        halt = 1; go("R3");
        stp = 1; go("R5");
        cp = 0; go("R9");
        w_rst = 1; w_init = 1; go("R10");
        chk("R10 normal after reset event", int'(st_oh), 5'b00001);
        chk("R10 cause reset", int'(cause), 1);
        cp = 1; go("R10");
        chk("R10 re-grant from normal", int'(st_oh), 5'b00100);
        stp = 0; go("R10");
        chk("R10 origin cleared", int'(st_oh), 5'b00001);

        // random phase
        for (int k = 0; k < N_RANDOM; k++) begin
            if ($urandom_range(11) == 0) stp = ~stp;
            if ($urandom_range(3) == 0)  inq = ~inq;
            if ($urandom_range(5) == 0)  cp = ~cp;
            halt   = ($urandom_range(4) == 0);
            w_init = ($urandom_range(15) == 0);
            w_smi  = ($urandom_range(15) == 0);
            w_nmi  = ($urandom_range(15) == 0);
            w_intr = ($urandom_range(15) == 0);
            w_rst  = ($urandom_range(99) == 0);
            cyc("R2", "R6", "R11", "R12");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule